// File: doc/BRIEF.md
# Serial Configuration Latch Port

This block lets an external controller program a small bank of configuration latches over three slow serial wires. The wires are a frame enable, a data line and a serial clock. A fourth wire carries read data back out. All three inputs are oversampled by the chip's system clock. Each one passes through a synchronizer chain at least two flops deep before any edge is detected. The serial clock therefore never drives a flop directly.

The data line is sampled on every rising serial-clock edge into a free-running shift register. That register keeps only the most recent frame-width bits. On the rising edge of the enable, the register contents are decoded. The last bit shifted in is the operation flag. The three bits before it are the latch address. The twelve bits before those are the data.

A write stores the data in the addressed latch. A read needs only the address and flag. It loads the addressed latch into an output shifter, which then sends the value MSB first on the data-out pin, one bit per falling serial-clock edge. Every latch is also presented in parallel to the rest of the chip.

Top module: `serial_cfg_port`

## Requirements
- R1: While `rst` is high, every latch clears to zero and `mfo_o` is low. Both are observed on the cycle after reset is applied.
- R2: At each rising edge of `sclk_i`, the value on `sdta_i` is shifted in. The shift register keeps only the latest 16 bits, with the newest bit at position 0.
- R3: Any bits shifted in before the final 16 of a frame are discarded. They have no effect on the latch that is written.
- R4: When `sden_i` rises, the 16-bit word is decoded as follows. Bit 0 is the operation flag, where 0 means write and 1 means read. Bits 3:1 are the latch address. Bits 15:4 are the data, with data bit 11 shifted in first. A write loads the data into the addressed latch only.
- R5: A read loads the addressed latch into the output shifter. `mfo_o` then shows data bit 11 first. It advances one bit after each falling edge of `sclk_i`, so each bit is stable across the following rising edge.
- R6: After the 12th falling `sclk_i` edge of a read, `mfo_o` returns low. It stays low until the next read.
- R7: A read frame never changes the contents of any latch.
- R8: Latches change only on a rising edge of `sden_i`. Serial-clock activity while `sden_i` stays high writes nothing. A later enable pulse with no new bits latches the bits already held.
- R9: A write frame shorter than 16 bits raises no error. The addressed latch receives whatever the last 16 bits were, including bits left over from earlier frames.
- R10: Latch k appears on `cfg_o[k*12 +: 12]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the external controller |
| sdta_i | input | 1 | Serial data, sampled on rising `sclk_i` |
| sden_i | input | 1 | Frame enable; its rising edge commits the frame |
| mfo_o | output | 1 | Serial read data, registered |
| cfg_o | output | 96 | All eight 12-bit latches, side by side |

## Verification
Every address is written and read back with three data patterns that differ from address to address. After each frame, all eight parallel outputs are compared against a bench model. This catches a wrong address decode, a wrong field position or a read that disturbs a latch.

Several boundary frames are also driven:
- Leading garbage bits are sent before a frame. A design that aligned to the first bits would store the garbage.
- A complete frame is clocked in while the enable stays high. A design that wrote on every sixteenth bit would change a latch there.
- A 4-bit write is sent, whose expected data is computed from the previous frame's leftover bits.

Read-back is checked bit by bit before each rising serial-clock edge, and again after the twelfth bit. This exposes a shifter that moves on the wrong edge, sends the LSB first, or keeps driving stale data.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cfgp_frame_rx.sv
module cfgp_frame_rx
  import cfgp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 3,
  localparam int FRAME_W = DATA_W + ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              commit,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      addr   <= '0;
      data   <= '0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (bit_stb) sr <= {sr[FRAME_W-2:0], bit_val};
      if (commit) begin
        addr <= sr[ADDR_W:1];
        data <= sr[FRAME_W-1:ADDR_W+1];
        if (op_e'(sr[0]) == OP_READ) rd_stb <= 1'b1;
        else                         wr_stb <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgp_latch_bank.sv
module cfgp_latch_bank #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 3,
  localparam int NUM = 1 << ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     waddr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [ADDR_W-1:0]     raddr,
  output logic [DATA_W-1:0]     rdata,
  output logic [NUM*DATA_W-1:0] flat_o
);
  logic [DATA_W-1:0] lat [NUM];

  for (genvar k = 0; k < NUM; k++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst)                               lat[k] <= '0;
      else if (we && waddr == ADDR_W'(k))    lat[k] <= wdata;
    end
    assign flat_o[k*DATA_W +: DATA_W] = lat[k];
  end

  assign rdata = lat[raddr];
endmodule

// File: rtl/cfgp_readout.sv
module cfgp_readout #(
  parameter int DATA_W = 12,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  output logic              mfo,
  output logic              busy
);
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      left <= '0;
      mfo  <= 1'b0;
    end else begin
      if (load) begin
        sr   <= load_data;
        left <= CNT_W'(DATA_W);
      end else if (shift && left != '0) begin
        sr   <= {sr[DATA_W-2:0], 1'b0};
        left <= left - 1'b1;
      end
      mfo <= (left != '0) & sr[DATA_W-1];
    end
  end

  assign busy = (left != '0);
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int DATA_W      = 12,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_LATCH  = 1 << ADDR_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sclk_i,
  input  logic                        sdta_i,
  input  logic                        sden_i,
  output logic                        mfo_o,
  output logic [NUM_LATCH*DATA_W-1:0] cfg_o
);
  logic [2:0]        pins_s;
  logic              sclk_q, sden_q;
  logic              sclk_rise, sclk_fall, sden_rise;
  logic              wr_stb, rd_stb, rd_busy;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data, rd_word;

  cfgp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({sden_i, sdta_i, sclk_i}),
    .q_o(pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      sden_q <= 1'b0;
    end else begin
      sclk_q <= pins_s[0];
      sden_q <= pins_s[2];
    end
  end

  assign sclk_rise =  pins_s[0] & ~sclk_q;
  assign sclk_fall = ~pins_s[0] &  sclk_q;
  assign sden_rise =  pins_s[2] & ~sden_q;

  cfgp_frame_rx #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst(rst),
    .bit_stb(sclk_rise), .bit_val(pins_s[1]), .commit(sden_rise),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(f_addr), .data(f_data)
  );

  cfgp_latch_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst),
    .we(wr_stb), .waddr(f_addr), .wdata(f_data),
    .raddr(f_addr), .rdata(rd_word), .flat_o(cfg_o)
  );

  cfgp_readout #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst),
    .load(rd_stb), .load_data(rd_word), .shift(sclk_fall),
    .mfo(mfo_o), .busy(rd_busy)
  );
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int CFG_W = 96
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic             sclk_fall,
  input logic             rd_busy,
  input logic             mfo_o,
  input logic [CFG_W-1:0] cfg_o
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cfg_o == '0 && !mfo_o));

  a_r8_write_only_on_commit: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(cfg_o));

  a_r7_read_keeps_latches: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> $stable(cfg_o));

  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_busy |=> !mfo_o);

  a_r5_moves_on_event: assert property (@(posedge clk) disable iff (rst)
    !$stable(mfo_o) |-> $past(sclk_fall || rd_stb, 2));
endmodule

bind serial_cfg_port cfgp_checker #(.CFG_W(NUM_LATCH*DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .sclk_fall(sclk_fall), .rd_busy(rd_busy), .mfo_o(mfo_o), .cfg_o(cfg_o)
);

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int AW = 3;
  localparam int NL = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdta = 1'b0, sden = 1'b1;
  logic mfo;
  logic [NL*DW-1:0] cfg;

  int checks = 0, fails = 0;
  logic [15:0] hist = '0;
  logic [DW-1:0] mdl [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_port u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdta_i(sdta), .sden_i(sden),
    .mfo_o(mfo), .cfg_o(cfg)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_latches(input string req);
    for (int k = 0; k < NL; k++)
      check({req, " R10"}, 32'(cfg[k*DW +: DW]), 32'(mdl[k]));
  endtask

  task automatic send_bit(input logic b);
    sdta = b;
    wait_clks(6);
    sclk = 1'b1;
    hist = {hist[14:0], b};
    wait_clks(6);
    sclk = 1'b0;
    wait_clks(6);
  endtask

  task automatic start_frame();
    sden = 1'b0;
    wait_clks(6);
  endtask

  task automatic end_frame();
    sden = 1'b1;
    wait_clks(10);
    if (hist[0] == 1'b0) mdl[hist[3:1]] = hist[15:4];
  endtask

  task automatic write_frame(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [15:0] w;
    w = {d, a, 1'b0};
    start_frame();
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
    end_frame();
  endtask

  task automatic read_frame(input logic [AW-1:0] a);
    logic [DW-1:0] e;
    e = mdl[a];
    start_frame();
    for (int i = AW-1; i >= 0; i--) send_bit(a[i]);
    send_bit(1'b1);
    end_frame();
    for (int i = DW-1; i >= 0; i--) begin
      check("R5 msb-first bit", 32'(mfo), 32'(e[i]));
      send_bit(1'b0);
    end
    check("R6 idle after word", 32'(mfo), 32'd0);
    check_latches("R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] x, v;
    for (int k = 0; k < NL; k++) mdl[k] = '0;
    wait_clks(5);
    rst = 1'b0;
    wait_clks(10);
    // R1: reset state
    check("R1 mfo", 32'(mfo), 32'd0);
    check_latches("R1");

    // R4 / R5 / R6 / R7: every address, three patterns
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < NL; a++) begin
        v = DW'((a * 12'h1A7 + p * 12'h5C3) ^ (p == 2 ? 12'hFFF : 12'h0));
        write_frame(AW'(a), v);
        check_latches("R4");
        read_frame(AW'(a));
      end
    end

    // R2 R3: leading garbage bits before a full frame
    start_frame();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    x = 12'h35A;
    begin
      logic [15:0] w;
      w = {x, 3'd5, 1'b0};
      for (int i = 15; i >= 0; i--) send_bit(w[i]);
    end
    end_frame();
    check("R2 R3 trailing bits kept", 32'(cfg[5*DW +: DW]), 32'(x));
    read_frame(3'd5);

    // R8: full write frame clocked while enable stays high
    begin
      logic [15:0] w;
      w = {12'hABC, 3'd1, 1'b0};
      for (int i = 15; i >= 0; i--) send_bit(w[i]);
    end
    check_latches("R8 no commit while high");
    // R8: empty enable pulse commits the held bits
    start_frame();
    end_frame();
    check("R8 R2 held bits commit", 32'(cfg[1*DW +: DW]), 32'h0ABC);

    // R9: short write takes leftovers of the previous frame
    x = 12'hC69;
    write_frame(3'd6, x);
    start_frame();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    end_frame();
    check("R9 short write", 32'(cfg[3*DW +: DW]), 32'({x[7:0], 3'd6, 1'b0}));
    check_latches("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule